// File: doc/BRIEF.md
# SPI Register and Buffer Command Decoder

This block is the host-facing front end of a peripheral that is controlled entirely over a serial port. The host frames each command with the active-low chip-select. The first byte of a command is a header. Its upper three bits choose an operation and its lower five bits carry either a register index or a fixed key value. Depending on the operation, the decoder does one of four things: it returns the contents of one of 32 eight-bit control registers, it writes, ORs into or masks such a register, it streams bytes to or from an external byte-wide buffer memory, or it arms a soft reset.

The serial pins are oversampled in the system clock domain. SCK idles low. Data is captured on the rising edge and shifted on the falling edge, most significant bit first. Each SCK phase must last at least 6 system clocks. The buffer memory is on the other side of a simple strobe port. A read strobe is answered on `buf_rdata_i` one clock later, and a write strobe carries its address and data in the same cycle. A byte pointer selects the buffer location. It advances by one on every strobe and persists across commands.

Top module: `spi_cmd_decoder`

## Requirements
- R1: SPI mode 0 with MSB first. Header bit 7..5 is the opcode and bit 4..0 is the argument. MISO is 0 while the header byte is shifted.
- R2: Opcode 010 stores the next byte into register `arg`. Any further bytes of that command leave registers unchanged.
- R3: Opcode 000 returns register `arg` in the first byte after the header. Later reply bytes of that command are 0.
- R4: Opcode 100 replaces register `arg` with its old value ORed with the next byte.
- R5: Opcode 101 replaces register `arg` with its old value ANDed with the inverse of the next byte.
- R6: Opcode 011 with argument 0x1A gives one `buf_wr_o` pulse per following byte. The pulse carries that byte on `buf_wdata_o` and the pointer on `buf_addr_o`, and the pointer then increases by one.
- R7: Opcode 001 with argument 0x1A pulses `buf_rd_o` at the end of the header and at the end of each reply byte, and the pointer then increases by one. Reply byte k holds the memory byte fetched by the k-th strobe.
- R8: These headers are ignored: opcode 110, opcode 001 or 011 with an argument other than 0x1A, and opcode 111 with an argument other than 0x1F. An ignored header causes no strobe and no register change, and MISO reads 0 until chip-select rises.
- R9: Header 0xFF has no effect until chip-select rises, and any bytes after it are ignored. When chip-select rises, `soft_rst_o` pulses for exactly one clock, all registers become 0 and the pointer becomes 0.
- R10: Chip-select rising in the middle of a byte discards the partial byte without a register update, and the next command decodes normally.
- R11: `buf_rd_o`, `buf_wr_o` and `soft_rst_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from host |
| csn_i | input | 1 | Active-low chip-select |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| buf_rd_o | output | 1 | Buffer read strobe |
| buf_wr_o | output | 1 | Buffer write strobe |
| buf_addr_o | output | BUF_AW | Buffer byte pointer |
| buf_wdata_o | output | 8 | Buffer write data |
| buf_rdata_i | input | 8 | Buffer read data, valid one clock after a read strobe |
| soft_rst_o | output | 1 | One-clock soft reset pulse |

## Verification
The bench builds the block with the default 8-bit buffer pointer and a 256-byte memory model in the bench, so every header encoding is in reach. All 256 header values are classified arithmetically, and each one that must be ignored is sent with trailing data. Every one of the 32 registers is written, read back, set and cleared with values computed from its index. Buffer streams, soft reset and mid-byte aborts are checked against a pointer model in the bench.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  typedef enum logic [2:0] {
    OP_RD_REG = 3'b000,
    OP_RD_BUF = 3'b001,
    OP_WR_REG = 3'b010,
    OP_WR_BUF = 3'b011,
    OP_SET    = 3'b100,
    OP_CLR    = 3'b101,
    OP_RSV    = 3'b110,
    OP_RST    = 3'b111
  } opcode_e;

  typedef enum logic [1:0] {UPD_WRITE, UPD_SET, UPD_CLR} upd_e;

  typedef enum logic [2:0] {
    ST_HDR, ST_DATA, ST_BUF_WR, ST_BUF_RD, ST_DRAIN, ST_RST_PEND
  } state_e;

  localparam logic [4:0] BUF_KEY = 5'h1A;
  localparam logic [7:0] RST_HDR = 8'hFF;
endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       csn_i,
  input  logic       mosi_i,
  output logic       miso_o,
  output logic       byte_valid_o,
  output logic [7:0] byte_o,
  output logic       cs_rise_o,
  input  logic       tx_load_i,
  input  logic [7:0] tx_data_i
);
  logic [1:0] sck_q, csn_q;
  logic       mosi_q;
  logic [2:0] bit_cnt_q;
  logic [6:0] rx_q;
  logic [7:0] tx_q;
  logic       rise, fall, active;

  assign rise      = sck_q[0] & ~sck_q[1];
  assign fall      = ~sck_q[0] & sck_q[1];
  assign active    = ~csn_q[0];
  assign cs_rise_o = csn_q[0] & ~csn_q[1];
  assign miso_o    = tx_q[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q        <= 2'b00;
      csn_q        <= 2'b11;
      mosi_q       <= 1'b0;
      bit_cnt_q    <= '0;
      rx_q         <= '0;
      tx_q         <= '0;
      byte_valid_o <= 1'b0;
      byte_o       <= '0;
    end else begin
      sck_q        <= {sck_q[0], sck_i};
      csn_q        <= {csn_q[0], csn_i};
      mosi_q       <= mosi_i;
      byte_valid_o <= 1'b0;
      if (!active) begin
        bit_cnt_q <= '0;
        tx_q      <= '0;
      end else begin
        if (rise) begin
          rx_q      <= {rx_q[5:0], mosi_q};
          bit_cnt_q <= bit_cnt_q + 3'd1;
          if (bit_cnt_q == 3'd7) begin
            byte_valid_o <= 1'b1;
            byte_o       <= {rx_q, mosi_q};
            tx_q         <= '0;  // next byte is zero unless loaded
          end
        end else if (fall && bit_cnt_q != 3'd0) begin
          tx_q <= {tx_q[6:0], 1'b0};
        end
        if (tx_load_i) tx_q <= tx_data_i;
      end
    end
  end

  assert_abort_clears_count_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise_o |=> (bit_cnt_q == 3'd0 && !miso_o));
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_cmd_pkg::*;
#(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  upd_e          upd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned NREG = 1 << AW;
  logic [DW-1:0] regs_q [NREG];

  assign rdata_o = regs_q[addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (clr_i) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      unique case (upd_i)
        UPD_SET: regs_q[addr_i] <= regs_q[addr_i] | wdata_i;
        UPD_CLR: regs_q[addr_i] <= regs_q[addr_i] & ~wdata_i;
        default: regs_q[addr_i] <= wdata_i;
      endcase
    end
  end

  assert_set_bits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !clr_i && upd_i == UPD_SET) |=>
      ((regs_q[$past(addr_i)] & $past(wdata_i)) == $past(wdata_i)));
  assert_clr_bits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !clr_i && upd_i == UPD_CLR) |=>
      ((regs_q[$past(addr_i)] & $past(wdata_i)) == '0));
  assert_clear_all_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (rdata_o == '0));
endmodule

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm
  import spi_cmd_pkg::*;
#(
  parameter int unsigned AW     = 5,
  parameter int unsigned BUF_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              cs_rise_i,
  output logic              tx_load_o,
  output logic [7:0]        tx_data_o,
  output logic              reg_we_o,
  output upd_e              reg_upd_o,
  output logic [AW-1:0]     reg_addr_o,
  output logic [7:0]        reg_wdata_o,
  input  logic [7:0]        reg_rdata_i,
  output logic              reg_clr_o,
  output logic              buf_rd_o,
  output logic              buf_wr_o,
  output logic [BUF_AW-1:0] buf_addr_o,
  output logic [7:0]        buf_wdata_o,
  input  logic [7:0]        buf_rdata_i,
  output logic              soft_rst_o
);
  state_e            state_q;
  upd_e              upd_q;
  logic [AW-1:0]     addr_q;
  logic [BUF_AW-1:0] ptr_q;
  logic              rd_pend_q;
  opcode_e           op;
  logic [4:0]        arg;
  logic              hdr_ev, rd_start, wr_start;

  assign op     = opcode_e'(byte_i[7:5]);
  assign arg    = byte_i[4:0];
  assign hdr_ev = byte_valid_i && state_q == ST_HDR;

  assign reg_addr_o  = (state_q == ST_HDR) ? byte_i[AW-1:0] : addr_q;
  assign reg_we_o    = byte_valid_i && state_q == ST_DATA;
  assign reg_upd_o   = upd_q;
  assign reg_wdata_o = byte_i;
  assign reg_clr_o   = cs_rise_i && state_q == ST_RST_PEND;
  assign buf_addr_o  = ptr_q;

  assign rd_start = (hdr_ev && op == OP_RD_BUF && arg == BUF_KEY) ||
                    (byte_valid_i && state_q == ST_BUF_RD);
  assign wr_start = byte_valid_i && state_q == ST_BUF_WR;

  always_comb begin
    tx_load_o = 1'b0;
    tx_data_o = '0;
    if (hdr_ev && op == OP_RD_REG) begin
      tx_load_o = 1'b1;
      tx_data_o = reg_rdata_i;
    end else if (rd_pend_q) begin
      tx_load_o = 1'b1;
      tx_data_o = buf_rdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_HDR;
      upd_q       <= UPD_WRITE;
      addr_q      <= '0;
      ptr_q       <= '0;
      rd_pend_q   <= 1'b0;
      buf_rd_o    <= 1'b0;
      buf_wr_o    <= 1'b0;
      buf_wdata_o <= '0;
      soft_rst_o  <= 1'b0;
    end else begin
      buf_rd_o   <= rd_start;
      buf_wr_o   <= wr_start;
      rd_pend_q  <= buf_rd_o;
      soft_rst_o <= reg_clr_o;
      if (wr_start) buf_wdata_o <= byte_i;
      if (reg_clr_o) ptr_q <= '0;
      else if (buf_rd_o || buf_wr_o) ptr_q <= ptr_q + 1'b1;

      if (cs_rise_i) begin
        state_q <= ST_HDR;
      end else if (byte_valid_i) begin
        unique case (state_q)
          ST_HDR: begin
            addr_q <= arg[AW-1:0];
            unique case (op)
              OP_WR_REG: begin state_q <= ST_DATA; upd_q <= UPD_WRITE; end
              OP_SET:    begin state_q <= ST_DATA; upd_q <= UPD_SET;   end
              OP_CLR:    begin state_q <= ST_DATA; upd_q <= UPD_CLR;   end
              OP_RD_BUF: state_q <= (arg == BUF_KEY) ? ST_BUF_RD : ST_DRAIN;
              OP_WR_BUF: state_q <= (arg == BUF_KEY) ? ST_BUF_WR : ST_DRAIN;
              OP_RST:    state_q <= (byte_i == RST_HDR) ? ST_RST_PEND : ST_DRAIN;
              default:   state_q <= ST_DRAIN;
            endcase
          end
          ST_DATA: state_q <= ST_DRAIN;
          default: state_q <= state_q;
        endcase
      end
    end
  end

  assert_strobe_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({buf_rd_o, buf_wr_o, soft_rst_o}));
  assert_ptr_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((buf_rd_o || buf_wr_o) && !reg_clr_o) |=> (buf_addr_o == $past(buf_addr_o) + 1'b1));
  assert_soft_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o);
  assert_drain_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRAIN && byte_valid_i) |=> (!buf_rd_o && !buf_wr_o && !tx_load_o));
  assert_hdr_after_cs_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise_i |=> state_q == ST_HDR);
endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
  import spi_cmd_pkg::*;
#(
  parameter int unsigned BUF_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              csn_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              buf_rd_o,
  output logic              buf_wr_o,
  output logic [BUF_AW-1:0] buf_addr_o,
  output logic [7:0]        buf_wdata_o,
  input  logic [7:0]        buf_rdata_i,
  output logic              soft_rst_o
);
  localparam int unsigned REG_AW = 5;

  logic              byte_valid, cs_rise, tx_load, reg_we, reg_clr;
  logic [7:0]        rx_byte, tx_data, reg_wdata, reg_rdata;
  logic [REG_AW-1:0] reg_addr;
  upd_e              reg_upd;

  spi_byte_shifter u_shift (
    .clk_i, .rst_ni, .sck_i, .csn_i, .mosi_i, .miso_o,
    .byte_valid_o (byte_valid),
    .byte_o       (rx_byte),
    .cs_rise_o    (cs_rise),
    .tx_load_i    (tx_load),
    .tx_data_i    (tx_data)
  );

  spi_cmd_fsm #(.AW(REG_AW), .BUF_AW(BUF_AW)) u_fsm (
    .clk_i, .rst_ni,
    .byte_valid_i (byte_valid),
    .byte_i       (rx_byte),
    .cs_rise_i    (cs_rise),
    .tx_load_o    (tx_load),
    .tx_data_o    (tx_data),
    .reg_we_o     (reg_we),
    .reg_upd_o    (reg_upd),
    .reg_addr_o   (reg_addr),
    .reg_wdata_o  (reg_wdata),
    .reg_rdata_i  (reg_rdata),
    .reg_clr_o    (reg_clr),
    .buf_rd_o, .buf_wr_o, .buf_addr_o, .buf_wdata_o, .buf_rdata_i, .soft_rst_o
  );

  spi_reg_bank #(.AW(REG_AW), .DW(8)) u_regs (
    .clk_i, .rst_ni,
    .clr_i   (reg_clr),
    .we_i    (reg_we),
    .upd_i   (reg_upd),
    .addr_i  (reg_addr),
    .wdata_i (reg_wdata),
    .rdata_o (reg_rdata)
  );
endmodule

// File: tb/spi_cmd_decoder_bench.sv
module spi_cmd_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;

  logic       clk = 1'b0;
  logic       rst_n, sck, csn, mosi, miso;
  logic       buf_rd, buf_wr, soft_rst;
  logic [7:0] buf_addr, buf_wdata;
  logic [7:0] buf_rdata = 8'h00;
  logic [7:0] mem [256];
  logic [7:0] model [32];
  int checks = 0, errors = 0;
  int rd_n = 0, wr_n = 0, soft_n = 0, exp_ptr = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_cmd_decoder u_spi_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .csn_i(csn), .mosi_i(mosi),
    .miso_o(miso), .buf_rd_o(buf_rd), .buf_wr_o(buf_wr), .buf_addr_o(buf_addr),
    .buf_wdata_o(buf_wdata), .buf_rdata_i(buf_rdata), .soft_rst_o(soft_rst)
  );

  always @(posedge clk) begin
    if (buf_wr) mem[buf_addr] <= buf_wdata;
    if (buf_rd) buf_rdata <= mem[buf_addr];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  logic soft_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (buf_rd || buf_wr) begin
        check(buf_addr == exp_ptr[7:0], buf_wr ? "R6 addr" : "R7 addr", buf_addr, exp_ptr[7:0]);
        exp_ptr = (exp_ptr + 1) % 256;
        if (buf_rd) rd_n++;
        if (buf_wr) wr_n++;
      end
      if (soft_rst) begin
        check(!soft_prev, "R9 pulse width", 2, 1);
        soft_n++;
        exp_ptr = 0;
      end
      soft_prev = soft_rst;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i >= 8 - nbits; i--) begin
      mosi = tx[i];
      tick(HALF);
      rx[i] = miso;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic cs_on();
    csn = 1'b0;
    tick(HALF);
  endtask

  task automatic cs_off();
    tick(HALF);
    csn = 1'b1;
    tick(6);
  endtask

  task automatic cmd2(input logic [7:0] hdr, input logic [7:0] d);
    logic [7:0] r;
    cs_on();
    xfer(hdr, 8, r);
    xfer(d, 8, r);
    cs_off();
  endtask

  task automatic read_reg(input int a, output logic [7:0] v, output logic [7:0] hdr_rx,
                          output logic [7:0] extra);
    cs_on();
    xfer({3'b000, a[4:0]}, 8, hdr_rx);
    xfer(8'h00, 8, v);
    xfer(8'h00, 8, extra);
    cs_off();
  endtask

  task automatic check_all_regs(input string req);
    logic [7:0] v, h, e;
    for (int a = 0; a < 32; a++) begin
      read_reg(a, v, h, e);
      check(v == model[a], req, v, model[a]);
    end
  endtask

  function automatic bit hdr_ok(input logic [7:0] h);
    case (h[7:5])
      3'd0, 3'd2, 3'd4, 3'd5: return 1'b1;
      3'd1, 3'd3:             return h[4:0] == 5'h1A;
      3'd7:                   return h == 8'hFF;
      default:                return 1'b0;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 190000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, h, e, r;
    int w0, r0, s0;
    rst_n = 1'b0; csn = 1'b1; sck = 1'b0; mosi = 1'b0;
    tick(5);
    check(miso == 1'b0, "R1 reset miso", miso, 0);
    check(soft_rst == 1'b0 && buf_rd == 1'b0 && buf_wr == 1'b0, "R11 reset strobes",
          {soft_rst, buf_rd, buf_wr}, 0);
    rst_n = 1'b1;
    tick(4);

    read_reg(0, v, h, e);
    check(v == 8'h00, "R3 reset value", v, 0);

    // R2/R3/R1: write and read every register
    for (int a = 0; a < 32; a++) begin
      model[a] = 8'((a * 37 + 11) & 255);
      cmd2({3'b010, a[4:0]}, model[a]);
    end
    for (int a = 0; a < 32; a++) begin
      read_reg(a, v, h, e);
      check(v == model[a], "R2 R3 readback", v, model[a]);
      check(h == 8'h00, "R1 header miso", h, 0);
      check(e == 8'h00, "R3 trailing zero", e, 0);
    end

    // R2: extra bytes after register write ignored
    cs_on(); xfer(8'h44, 8, r); xfer(8'h11, 8, r); xfer(8'h22, 8, r); cs_off();
    model[4] = 8'h11;
    read_reg(4, v, h, e);
    check(v == 8'h11, "R2 extra bytes", v, 8'h11);

    // R4 set, R5 clear
    for (int a = 0; a < 32; a++) begin
      logic [7:0] m;
      m = 8'((a * 29 + 8'h5A) & 255);
      model[a] = model[a] | m;
      cmd2({3'b100, a[4:0]}, m);
    end
    check_all_regs("R4 set");
    for (int a = 0; a < 32; a++) begin
      logic [7:0] m;
      m = 8'((a * 53 + 8'h0F) & 255);
      model[a] = model[a] & ~m;
      cmd2({3'b101, a[4:0]}, m);
    end
    check_all_regs("R5 clear");

    // R6: buffer write stream
    cs_on();
    xfer(8'h7A, 8, r);
    for (int i = 0; i < 16; i++) xfer(8'((i * 13 + 1) & 255), 8, r);
    cs_off();
    check(wr_n == 16, "R6 strobe count", wr_n, 16);
    for (int i = 0; i < 16; i++)
      check(mem[i] == 8'((i * 13 + 1) & 255), "R6 data", mem[i], (i * 13 + 1) & 255);

    // R9: soft reset waits for chip-select
    cs_on(); xfer(8'hFF, 8, r); xfer(8'h12, 8, r); tick(20);
    check(soft_n == 0, "R9 early", soft_n, 0);
    cs_off();
    check(soft_n == 1, "R9 pulse", soft_n, 1);
    check(exp_ptr == 0 && buf_addr == 8'h00, "R9 pointer", buf_addr, 0);
    for (int a = 0; a < 32; a++) model[a] = 8'h00;
    check_all_regs("R9 regs zero");

    // R7: buffer read stream from pointer 0
    cs_on();
    xfer(8'h3A, 8, r);
    check(r == 8'h00, "R1 header miso", r, 0);
    for (int k = 0; k < 5; k++) begin
      xfer(8'h00, 8, r);
      check(r == 8'((k * 13 + 1) & 255), "R7 data", r, (k * 13 + 1) & 255);
    end
    cs_off();
    check(rd_n == 6, "R7 strobe count", rd_n, 6);

    // R8: sweep all ignored headers
    for (int a = 0; a < 32; a++) begin
      model[a] = 8'((a * 37 + 11) & 255);
      cmd2({3'b010, a[4:0]}, model[a]);
    end
    w0 = wr_n; r0 = rd_n; s0 = soft_n;
    for (int hv = 0; hv < 256; hv++) begin
      if (!hdr_ok(8'(hv))) begin
        logic [7:0] x1, x2;
        cs_on(); xfer(8'(hv), 8, r); xfer(8'hA5, 8, x1); xfer(8'h5A, 8, x2); cs_off();
        check(x1 == 8'h00 && x2 == 8'h00, "R8 miso zero", {x1, x2}, 0);
      end
    end
    check(wr_n == w0 && rd_n == r0, "R8 no strobes", wr_n + rd_n, w0 + r0);
    check(soft_n == s0, "R8 no reset", soft_n, s0);
    check_all_regs("R8 regs kept");

    // R10: aborts mid-byte
    cs_on(); xfer(8'h43, 8, r); xfer(8'hEE, 4, r); cs_off();
    read_reg(3, v, h, e);
    check(v == model[3], "R10 abort data", v, model[3]);
    cs_on(); xfer(8'h45, 5, r); cs_off();
    cmd2(8'h45, 8'h3C);
    model[5] = 8'h3C;
    read_reg(5, v, h, e);
    check(v == 8'h3C, "R10 after abort", v, 8'h3C);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule